// File: doc/BRIEF.md
# Quadrature Down-Mixer and Two-Stage Sinc4 Decimator

This block sits at the head of a digital receive chain. It accepts one signed sample per clock enable from an oversampling modulator. It rotates the stream down by one eighth of the sample rate with a complex local oscillator, which yields an in-phase (cosine-weighted) and a quadrature (sine-weighted) path. Each path then runs through two fourth-order comb decimators in cascade. The first stage divides the rate by a fixed 12. The second stage divides by a programmable M+1.

The block emits I and Q words together under a single valid strobe. It also reports the composite decimation ratio that a later fixed-ratio stage will complete. That final stage divides by 5 or by 4, so the composite ratio is 60·(M+1) or 48·(M+1). A load strobe latches new settings and restarts the whole chain. A setting change therefore never produces an output built from a partial decimation period.

Top module: `quad_cic_front`

## Requirements
- R1: While rst_n is low at a rising edge, the chain clears, M clears to 0 and the ratio select clears to 0. After reset, out_valid is 0, out_i and out_q are 0 and dec_ratio is 60.
- R2: The oscillator phase index starts at 0 after reset or load and advances by one, modulo 8, per accepted sample. At phase index p the cosine weight is 127, 90, 0, −90, −127, −90, 0, 90 for p = 0..7, and the sine weight is the cosine weight at index p−2. The I path input is the sample times the cosine weight and the Q path input is the sample times the sine weight.
- R3: Stage one is a sinc4 decimator by 12. Its outputs are exactly the sum, over the newest 45 mixed samples, of the sample times the taps of four cascaded length-12 boxcars, and it emits one output on every 12th accepted sample.
- R4: Stage two is a sinc4 decimator by M+1 over the stage-one outputs, with the same construction, and its result is out_i and out_q with exact (non-overflowing) value for all inputs and all M. I and Q share the same delay.
- R5: out_valid is a one-cycle pulse. It rises at the second rising edge after the accepted sample that completes each group of 12·(M+1) accepted samples.
- R6: A cycle with in_en low changes no state: no sample, phase step or count is taken.
- R7: dec_ratio equals 60·(M+1) when the latched ratio select is 0 and 48·(M+1) when it is 1.
- R8: Changes on m_cfg or k_sel without m_load have no effect on dec_ratio, the pulse spacing or the output values.
- R9: A rising edge with m_load high latches m_cfg and k_sel and clears all filter state, counters and phase. It drops any sample offered in that cycle and cancels any output pulse still in flight, so out_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_en | input | 1 | Sample accept enable |
| in_data | input | IN_W (4) | Signed modulator sample |
| m_cfg | input | M_W (6) | Stage-two ratio minus one, taken on load |
| k_sel | input | 1 | Final-stage select: 0 for divide by 5, 1 for divide by 4, taken on load |
| m_load | input | 1 | Latch settings and restart the chain |
| out_valid | output | 1 | One-cycle strobe for out_i and out_q |
| out_i | output | S2_W (52) | Signed in-phase result |
| out_q | output | S2_W (52) | Signed quadrature result |
| dec_ratio | output | RAT_W (12) | Composite decimation ratio |

## Verification
Two events can land on the same edge: a load and a decimated output that is about to be released from stage two. The bench runs its reference model until an output is due on the next edge and then raises m_load together with an accepted sample on that edge. It expects out_valid to stay low, the sample to be discarded and the counts to restart from zero. A second collision, a new stage-one result entering stage two on the same edge as a fresh accepted sample, occurs on every twelfth sample and is judged by the per-cycle value comparison.

// File: rtl/quad_cic_front.sv
module quad_cic_front #(
  parameter int IN_W = 4,
  parameter int LO_W = 8,
  parameter int M_W  = 6,
  parameter int R1   = 12,
  localparam int C1_W  = $clog2(R1),
  localparam int MIX_W = IN_W + LO_W,
  localparam int S1_W  = MIX_W + 4 * C1_W,
  localparam int S2_W  = S1_W + 4 * M_W,
  localparam int RAT_W = M_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [IN_W-1:0]  in_data,
  input  logic [M_W-1:0]   m_cfg,
  input  logic             k_sel,
  input  logic             m_load,
  output logic             out_valid,
  output logic [S2_W-1:0]  out_i,
  output logic [S2_W-1:0]  out_q,
  output logic [RAT_W-1:0] dec_ratio
);

  localparam int LO_FULL = 2 ** (LO_W - 1) - 1;
  localparam int LO_DIAG = (LO_FULL * 181 + 128) / 256;

  function automatic logic signed [LO_W-1:0] lo_tap(input logic [2:0] p);
    case (p)
      3'd0:       return LO_W'(LO_FULL);
      3'd1, 3'd7: return LO_W'(LO_DIAG);
      3'd3, 3'd5: return LO_W'(-LO_DIAG);
      3'd4:       return LO_W'(-LO_FULL);
      default:    return '0;
    endcase
  endfunction

  logic             clr;
  logic [2:0]       ph;
  logic [C1_W-1:0]  c1;
  logic [M_W-1:0]   c2;
  logic [M_W-1:0]   m_act;
  logic             k_act;
  logic             s1_v;

  logic signed [MIX_W-1:0] xin, mix [2];
  logic signed [S1_W-1:0]  a1 [2][4], z1 [2][4], n1 [2][4], d1 [2][5], s1 [2];
  logic signed [S2_W-1:0]  a2 [2][4], z2 [2][4], n2 [2][4], d2 [2][5];

  assign clr = !rst_n || m_load;
  assign xin = MIX_W'($signed(in_data));
  assign dec_ratio = (k_act ? RAT_W'(48) : RAT_W'(60)) * (RAT_W'(m_act) + RAT_W'(1));

  always_comb begin
    mix[0] = xin * MIX_W'(lo_tap(ph));
    mix[1] = xin * MIX_W'(lo_tap(ph - 3'd2));
    for (int p = 0; p < 2; p++) begin
      n1[p][0] = a1[p][0] + S1_W'(mix[p]);
      for (int k = 1; k < 4; k++) n1[p][k] = a1[p][k] + n1[p][k-1];
      d1[p][0] = n1[p][3];
      for (int k = 0; k < 4; k++) d1[p][k+1] = d1[p][k] - z1[p][k];
      n2[p][0] = a2[p][0] + S2_W'(s1[p]);
      for (int k = 1; k < 4; k++) n2[p][k] = a2[p][k] + n2[p][k-1];
      d2[p][0] = n2[p][3];
      for (int k = 0; k < 4; k++) d2[p][k+1] = d2[p][k] - z2[p][k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_act <= '0;
      k_act <= 1'b0;
    end else if (m_load) begin
      m_act <= m_cfg;
      k_act <= k_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ph        <= '0;
      c1        <= '0;
      c2        <= '0;
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      for (int p = 0; p < 2; p++) begin
        s1[p] <= '0;
        for (int k = 0; k < 4; k++) begin
          a1[p][k] <= '0;
          z1[p][k] <= '0;
          a2[p][k] <= '0;
          z2[p][k] <= '0;
        end
      end
    end else begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      if (in_en) begin
        ph <= ph + 3'd1;
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 4; k++) a1[p][k] <= n1[p][k];
        if (c1 == C1_W'(R1 - 1)) begin
          c1   <= '0;
          s1_v <= 1'b1;
          for (int p = 0; p < 2; p++) begin
            s1[p] <= d1[p][4];
            for (int k = 0; k < 4; k++) z1[p][k] <= d1[p][k];
          end
        end else begin
          c1 <= c1 + C1_W'(1);
        end
      end
      if (s1_v) begin
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 4; k++) a2[p][k] <= n2[p][k];
        if (c2 == m_act) begin
          c2        <= '0;
          out_valid <= 1'b1;
          out_i     <= d2[0][4];
          out_q     <= d2[1][4];
          for (int p = 0; p < 2; p++)
            for (int k = 0; k < 4; k++) z2[p][k] <= d2[p][k];
        end else begin
          c2 <= c2 + M_W'(1);
        end
      end
    end
  end

endmodule

module quad_cic_front_chk #(
  parameter int M_W   = 6,
  parameter int RAT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_en,
  input logic             m_load,
  input logic             k_sel,
  input logic [M_W-1:0]   m_cfg,
  input logic             out_valid,
  input logic [RAT_W-1:0] dec_ratio
);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_pulse_follows_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_en, 2) && !$past(m_load, 1) && !$past(m_load, 2)));

  p_load_cancels_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_load |=> !out_valid);

  p_ratio_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !m_load |=> $stable(dec_ratio));

  p_ratio_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_load |=> (int'(dec_ratio) == ($past(k_sel) ? 48 : 60) * (int'($past(m_cfg)) + 1)));

endmodule

bind quad_cic_front quad_cic_front_chk #(.M_W(M_W), .RAT_W(RAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_en(in_en), .m_load(m_load), .k_sel(k_sel),
  .m_cfg(m_cfg), .out_valid(out_valid), .dec_ratio(dec_ratio)
);

// File: tb/quad_cic_front_bench.sv
module quad_cic_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 4;
  localparam int M_W  = 6;
  localparam int OW   = 52;
  localparam int RW   = 12;

  logic clk = 1'b0, rst_n = 1'b0, in_en = 1'b0, k_sel = 1'b0, m_load = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [M_W-1:0]  m_cfg = '0;
  logic            out_valid;
  logic [OW-1:0]   out_i, out_q;
  logic [RW-1:0]   dec_ratio;

  quad_cic_front u_quad_cic_front (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_data(in_data), .m_cfg(m_cfg),
    .k_sel(k_sel), .m_load(m_load), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .dec_ratio(dec_ratio)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0, checks = 0;
  string tag = "R1";

  longint hi[$], hq[$], si[$], sq[$], h1[$], h2[$], tp[$];
  int n1 = 0, n2 = 0, ph = 0, mact = 0, kact = 0;
  bit s1pend = 0, vexp = 0;
  longint s1pi = 0, s1pq = 0, ei = 0, eq = 0;

  function automatic int lo(input int p);
    case (p & 7)
      0: return 127;
      1, 7: return 90;
      3, 5: return -90;
      4: return -127;
      default: return 0;
    endcase
  endfunction

  task automatic make_taps(input int r);
    tp = {1};
    repeat (4) begin
      longint nx[$];
      nx = {};
      for (int j = 0; j < tp.size() + r - 1; j++) begin
        longint s = 0;
        for (int b = 0; b < r; b++)
          if (j - b >= 0 && j - b < tp.size()) s += tp[j-b];
        nx.push_back(s);
      end
      tp = nx;
    end
  endtask

  function automatic longint fir(input longint h[$], input longint x[$]);
    longint s = 0;
    for (int k = 0; k < h.size(); k++)
      if (x.size() - 1 - k >= 0) s += h[k] * x[x.size()-1-k];
    return s;
  endfunction

  task automatic model_step(input bit en, input int x, input bit ld);
    if (ld) begin
      hi = {}; hq = {}; si = {}; sq = {};
      n1 = 0; n2 = 0; ph = 0; s1pend = 0; vexp = 0;
      mact = int'(m_cfg); kact = int'(k_sel);
      make_taps(mact + 1); h2 = tp;
      return;
    end
    vexp = 0;
    if (s1pend) begin
      si.push_back(s1pi); sq.push_back(s1pq);
      if (n2 == mact) begin
        ei = fir(h2, si); eq = fir(h2, sq); vexp = 1; n2 = 0;
      end else n2++;
    end
    s1pend = 0;
    if (en) begin
      hi.push_back(longint'(x * lo(ph)));
      hq.push_back(longint'(x * lo(ph + 6)));
      ph = (ph + 1) % 8;
      if (n1 == 11) begin
        s1pi = fir(h1, hi); s1pq = fir(h1, hq); s1pend = 1; n1 = 0;
      end else n1++;
    end
    while (hi.size() > 400) begin void'(hi.pop_front()); void'(hq.pop_front()); end
    while (si.size() > 400) begin void'(si.pop_front()); void'(sq.pop_front()); end
  endtask

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s]: actual=%0d expected=%0d", what, tag, act, exp);
    end
  endtask

  task automatic compare();
    longint er;
    er = longint'((kact != 0 ? 48 : 60) * (mact + 1));
    chk(out_valid == vexp, "R5 out_valid", longint'(out_valid), longint'(vexp));
    if (vexp && out_valid) begin
      chk(longint'($signed(out_i)) == ei, "R2 R3 R4 out_i", longint'($signed(out_i)), ei);
      chk(longint'($signed(out_q)) == eq, "R2 R3 R4 out_q", longint'($signed(out_q)), eq);
    end
    chk(longint'(dec_ratio) == er, "R7 dec_ratio", longint'(dec_ratio), er);
  endtask

  task automatic cyc(input bit en, input int x, input bit ld);
    in_en = en; in_data = IN_W'(x); m_load = ld;
    @(posedge clk);
    model_step(en, x, ld);
    @(negedge clk);
    compare();
  endtask

  function automatic int rnd();
    int v = int'($urandom_range(0, 15));
    return (v > 7) ? v - 16 : v;
  endfunction

  task automatic run_to_pending();
    for (int g = 0; g < 10000 && !(s1pend && n2 == mact); g++) cyc(1'b1, rnd(), 1'b0);
  endtask

  initial begin
    make_taps(12); h1 = tp;
    make_taps(1);  h2 = tp;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    chk(out_i == '0 && out_q == '0, "R1 reset outputs", longint'($signed(out_i)), 0);
    chk(dec_ratio == RW'(60), "R1 reset dec_ratio", longint'(dec_ratio), 60);

    tag = "R2 R3 R4 R5 M=0";
    for (int i = 0; i < 300; i++) cyc(1'b1, rnd(), 1'b0);

    tag = "R6 gated enable";
    for (int i = 0; i < 300; i++) cyc(1'($urandom_range(0, 1)), rnd(), 1'b0);
    for (int i = 0; i < 60; i++) cyc(1'b0, rnd(), 1'b0);

    tag = "R7 M=14 K=0";
    m_cfg = 6'd14; k_sel = 1'b0;
    cyc(1'b0, 0, 1'b1);
    chk(dec_ratio == RW'(900), "R7 ratio 900", longint'(dec_ratio), 900);
    for (int i = 0; i < 2000; i++) cyc(1'b1, rnd(), 1'b0);

    tag = "R8 settings without load";
    m_cfg = 6'd3; k_sel = 1'b1;
    for (int i = 0; i < 400; i++) cyc(1'b1, rnd(), 1'b0);
    chk(dec_ratio == RW'(900), "R8 ratio unchanged", longint'(dec_ratio), 900);

    tag = "R7 M=3 K=1";
    cyc(1'b1, rnd(), 1'b1);
    chk(dec_ratio == RW'(192), "R7 ratio 192", longint'(dec_ratio), 192);
    for (int i = 0; i < 500; i++) cyc(1'b1, rnd(), 1'b0);

    tag = "R9 load on pending output";
    run_to_pending();
    m_cfg = 6'd63; k_sel = 1'b1;
    cyc(1'b1, rnd(), 1'b1);
    chk(out_valid == 1'b0, "R9 cancelled pulse", longint'(out_valid), 0);
    chk(dec_ratio == RW'(3072), "R9 ratio 3072", longint'(dec_ratio), 3072);

    tag = "R3 R4 full-scale M=63";
    for (int i = 0; i < 3100; i++) cyc(1'b1, -8, 1'b0);

    tag = "R9 restart to M=0";
    m_cfg = 6'd0; k_sel = 1'b0;
    run_to_pending();
    cyc(1'b1, 7, 1'b1);
    for (int i = 0; i < 200; i++) cyc(1'b1, rnd(), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog [%s]: actual=timeout expected=completion", tag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule